// File: doc/BRIEF.md
# AEGIS-128 State Update Step

This block advances the five-word authenticated-encryption state of the AEGIS-128 construction by one step. Each state word is 128 bits. A 128-bit message word is absorbed in the same step. Every new word is the old word XORed with an unkeyed AES round of its neighbour. The first word also absorbs the message. All new words are computed from the old words only, so the five round lanes work side by side and there is no chain between them.

The step sits on a valid/ready stream. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. In the registered build (`REGISTERED = 1`), the result is held in an output register and is offered with `out_valid`. The register holds its word while `out_ready` is low. The input accepts a new word whenever the output slot is empty or is being drained in the same cycle. In the combinational build (`REGISTERED = 0`), the next state appears on `out_state` in the same cycle. Valid and ready pass straight through that build. An outer sequencer feeds the step in a loop; this block does not do that sequencing.

Top module: `aegis_update`

## Requirements
- R1: The new first word is the old first word XOR R(old last word) XOR the message word, with W = WORDS words and the last word at index W-1.
- R2: For each word i from 1 to W-1, the new word i is the old word i XOR R(old word i-1).
- R3: R is one AES round with a zero round key. The steps are: permute bytes (output byte i takes input byte (i + 4*(i mod 4)) mod 16), substitute each byte through the AES S-box, then mix columns. Byte 0 is the least significant byte of a word, and bytes 4c to 4c+3 form column c. One known pair, written byte 0 first, is input 19 3d e3 be a0 f4 e2 2b 9a c6 8d 2a e9 f8 48 08 and output 04 66 81 e5 e0 cb 19 9a 48 f8 d3 7a 28 06 26 4c.
- R4: Mixing a column uses GF(2^8) doubling: shift left by one and XOR 0x1B when the top bit was set. A column of four equal bytes mixes to itself, so R of sixteen equal bytes b is sixteen copies of S-box(b). The bench relies on S-box(00)=63, S-box(01)=7c, S-box(02)=77, S-box(53)=ed and S-box(ff)=16.
- R5: Registered build: on an edge with in_valid and in_ready high, out_state takes the next state and out_valid is high after that edge.
- R6: Registered build: while out_valid is high and out_ready is low, out_state and out_valid hold across edges.
- R7: Registered build: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: A synchronous reset edge (rst high) clears out_state to zero and out_valid to low.
- R9: Combinational build: out_state equals the next state of the present inputs in the same cycle, out_valid follows in_valid, and in_ready follows out_ready.
- R10: Registered build: on an edge with no transfer, out_state keeps its value. When out_ready is high and in_valid is low, out_valid drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input state and message are offered |
| in_ready | output | 1 | Block can take the offered input |
| in_state | input | WORDS*128 | Old state, word i at bits 128*i upward |
| in_msg | input | 128 | Message word absorbed into word 0 |
| out_valid | output | 1 | out_state holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_state | output | WORDS*128 | New state, same layout as in_state |

## Verification
The bench builds two copies with the default five words: one with `REGISTERED = 1` and one with `REGISTERED = 0`. Both copies get the same vectors, so the registered handshake and the same-cycle path are compared against one expected state. The state words are drawn from inputs whose round output is known: a published single-round pair and uniform-byte words. This makes every lane, the cyclic neighbour wrap from the last word to the first, and the message injection visible without a software model of the round. The registered copy's ready output is then driven through stall, drain, idle and reset.

// File: rtl/aegis_pkg.sv
package aegis_pkg;
  localparam int BLK_W     = 128;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int COL_BYTES = 4;
  localparam int NUM_COLS  = BLK_BYTES / COL_BYTES;

  // doubling in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // AES substitution: multiplicative inverse (x^254) then affine map
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] p2, p4, p8, p16, p32, p64, p128, inv;
    p2   = gf_mul(x, x);
    p4   = gf_mul(p2, p2);
    p8   = gf_mul(p4, p4);
    p16  = gf_mul(p8, p8);
    p32  = gf_mul(p16, p16);
    p64  = gf_mul(p32, p32);
    p128 = gf_mul(p64, p64);
    inv  = gf_mul(gf_mul(gf_mul(p2, p4), gf_mul(p8, p16)),
                  gf_mul(gf_mul(p32, p64), p128));
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aegis_sbox.sv
module aegis_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  assign dout = aegis_pkg::sbox_calc(din);
endmodule

// File: rtl/aegis_round.sv
module aegis_round
  import aegis_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  logic [BLK_W-1:0] perm;
  logic [BLK_W-1:0] subst;

  // byte permutation, then substitution per byte
  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
    localparam int SRC = (i + COL_BYTES * (i % COL_BYTES)) % BLK_BYTES;
    assign perm[8*i +: 8] = din[8*SRC +: 8];
    aegis_sbox u_sb (
      .din  (perm[8*i +: 8]),
      .dout (subst[8*i +: 8])
    );
  end

  // column mixing: out_k = a_k ^ (a0^a1^a2^a3) ^ 2*(a_k ^ a_{k+1})
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [7:0] col_sum;
    assign col_sum = subst[32*c +: 8] ^ subst[32*c+8 +: 8]
                   ^ subst[32*c+16 +: 8] ^ subst[32*c+24 +: 8];
    for (genvar k = 0; k < COL_BYTES; k++) begin : g_row
      localparam int CUR = COL_BYTES * c + k;
      localparam int NXT = COL_BYTES * c + (k + 1) % COL_BYTES;
      assign dout[8*CUR +: 8] = subst[8*CUR +: 8] ^ col_sum
                              ^ gf_dbl(subst[8*CUR +: 8] ^ subst[8*NXT +: 8]);
    end
  end
endmodule

// File: rtl/aegis_step.sv
module aegis_step
  import aegis_pkg::*;
#(
  parameter int WORDS = 5
) (
  input  logic [WORDS*BLK_W-1:0] st,
  input  logic [BLK_W-1:0]       msg,
  output logic [WORDS*BLK_W-1:0] nxt
);
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    localparam int PREV = (w + WORDS - 1) % WORDS;
    logic [BLK_W-1:0] mixed;
    aegis_round u_rnd (
      .din  (st[BLK_W*PREV +: BLK_W]),
      .dout (mixed)
    );
    if (w == 0) begin : g_inject
      assign nxt[BLK_W*w +: BLK_W] = st[BLK_W*w +: BLK_W] ^ mixed ^ msg;
    end else begin : g_plain
      assign nxt[BLK_W*w +: BLK_W] = st[BLK_W*w +: BLK_W] ^ mixed;
    end
  end
endmodule

// File: rtl/aegis_update.sv
module aegis_update
  import aegis_pkg::*;
#(
  parameter int WORDS      = 5,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [WORDS*aegis_pkg::BLK_W-1:0] in_state,
  input  logic [aegis_pkg::BLK_W-1:0]       in_msg,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [WORDS*aegis_pkg::BLK_W-1:0] out_state
);
  localparam int STATE_W = WORDS * BLK_W;

  logic [STATE_W-1:0] next_state;

  aegis_step #(.WORDS(WORDS)) u_step (
    .st  (in_state),
    .msg (in_msg),
    .nxt (next_state)
  );

  if (REGISTERED) begin : g_reg
    logic [STATE_W-1:0] state_q;
    logic               valid_q;
    logic               take;

    assign in_ready = !valid_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        state_q <= '0;
      end else begin
        if (in_ready) valid_q <= in_valid;
        if (take)     state_q <= next_state;
      end
    end

    assign out_state = state_q;
    assign out_valid = valid_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign out_state = next_state;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end
endmodule

// File: rtl/aegis_update_chk.sv
module aegis_update_chk #(
  parameter int STATE_W    = 640,
  parameter bit REGISTERED = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [STATE_W-1:0] out_state
);
  // R7 / R9: an offered result that is not taken blocks the input
  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  if (REGISTERED) begin : g_seq
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_state)));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

    p_keep_r10: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> $stable(out_state));

    p_drain_r10: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && out_ready) |=> !out_valid);

    p_clear_r8: assert property (@(posedge clk)
      rst |=> (!out_valid && (out_state == '0)));
  end
endmodule

bind aegis_update aegis_update_chk #(.STATE_W(STATE_W), .REGISTERED(REGISTERED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_state (out_state)
);

// File: tb/sim_aegis_update.sv
module sim_aegis_update;
  localparam int SW = 640;
  localparam int NV = 7;
  localparam logic [127:0] FIPS_IN  = 128'h0848f8e92a8dc69a2be2f4a0bee33d19;
  localparam logic [127:0] FIPS_OUT = 128'h4c2606287ad3f8489a19cbe0e5816604;

  // stimulus table: five 3-bit word selectors {w4,w3,w2,w1,w0} and a message
  localparam logic [14:0] SEL [NV] = '{
    {3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
    {3'd0, 3'd0, 3'd0, 3'd0, 3'd1},
    {3'd1, 3'd5, 3'd4, 3'd3, 3'd2},
    {3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
    {3'd3, 3'd3, 3'd3, 3'd3, 3'd3},
    {3'd1, 3'd2, 3'd3, 3'd4, 3'd5},
    {3'd1, 3'd1, 3'd1, 3'd1, 3'd1}};
  localparam logic [127:0] MSG [NV] = '{
    128'h0,
    128'h0,
    128'h0123456789abcdeffedcba9876543210,
    {16{8'hff}},
    128'h0,
    128'hdeadbeef00c0ffee1234abcd55aa33cc,
    {16{8'ha5}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic rdy0 = 1'b1, rdy1 = 1'b1;
  logic [SW-1:0]  in_state = '0;
  logic [127:0]   in_msg = '0;
  logic           in_ready0, in_ready1, out_valid0, out_valid1;
  logic [SW-1:0]  out_state0, out_state1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aegis_update #(.WORDS(5), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready0),
    .in_state(in_state), .in_msg(in_msg), .out_valid(out_valid0),
    .out_ready(rdy0), .out_state(out_state0));

  aegis_update #(.WORDS(5), .REGISTERED(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready1),
    .in_state(in_state), .in_msg(in_msg), .out_valid(out_valid1),
    .out_ready(rdy1), .out_state(out_state1));

  function automatic logic [127:0] kword(input logic [2:0] s);
    case (s)
      3'd1:    return FIPS_IN;
      3'd2:    return {16{8'h01}};
      3'd3:    return {16{8'h53}};
      3'd4:    return {16{8'hff}};
      3'd5:    return {16{8'h02}};
      default: return 128'h0;
    endcase
  endfunction

  function automatic logic [127:0] kround(input logic [2:0] s);
    case (s)
      3'd1:    return FIPS_OUT;
      3'd2:    return {16{8'h7c}};
      3'd3:    return {16{8'hed}};
      3'd4:    return {16{8'h16}};
      3'd5:    return {16{8'h77}};
      default: return {16{8'h63}};
    endcase
  endfunction

  function automatic logic [SW-1:0] build(input logic [14:0] s);
    logic [SW-1:0] v;
    for (int w = 0; w < 5; w++) v[128*w +: 128] = kword(s[3*w +: 3]);
    return v;
  endfunction

  function automatic logic [SW-1:0] expect_next(input logic [14:0] s, input logic [127:0] m);
    logic [SW-1:0] e;
    for (int w = 0; w < 5; w++) begin
      e[128*w +: 128] = kword(s[3*w +: 3]) ^ kround(s[3*((w + 4) % 5) +: 3]);
      if (w == 0) e[127:0] = e[127:0] ^ m;
    end
    return e;
  endfunction

  task automatic check(input logic ok, input string req, input logic [SW-1:0] got,
                       input logic [SW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [SW-1:0] e_last, e_x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check(out_valid0 == 1'b0 && out_state0 == '0, "R8 reset state",
          {out_valid0, out_state0[SW-2:0]}, '0);
    check(in_ready0 == 1'b1, "R7 ready when empty", SW'(in_ready0), SW'(1));

    // table walk: R1, R2 on both builds, R9 on the combinational one
    for (int v = 0; v < NV; v++) begin
      logic [SW-1:0] e;
      e = expect_next(SEL[v], MSG[v]);
      in_state = build(SEL[v]);
      in_msg   = MSG[v];
      in_valid = 1'b1;
      #1;
      check(out_state1 == e && out_valid1, "R9 same-cycle result R1 R2", out_state1, e);
      @(negedge clk);
      check(out_state0 == e, "R1 R2 registered result", out_state0, e);
      check(out_valid0 == 1'b1, "R5 valid after transfer", SW'(out_valid0), SW'(1));
      e_last = e;
    end

    // R3: isolated round on word 1 (S0 = known input, others zero)
    in_state = build({3'd0, 3'd0, 3'd0, 3'd0, 3'd1});
    in_msg   = '0;
    #1;
    check(out_state1[255:128] == FIPS_OUT, "R3 round of known vector",
          SW'(out_state1[255:128]), SW'(FIPS_OUT));
    // R4: uniform words map to the S-box value of their byte
    in_state = build({3'd0, 3'd0, 3'd0, 3'd4, 3'd0});
    #1;
    check(out_state1[383:256] == {16{8'h16}}, "R4 uniform-byte round",
          SW'(out_state1[383:256]), SW'({16{8'h16}}));
    @(negedge clk);
    e_last = expect_next({3'd0, 3'd0, 3'd0, 3'd4, 3'd0}, 128'h0);

    // R6, R7: stall with a new input waiting
    rdy0 = 1'b0;
    in_state = build(SEL[5]);
    in_msg   = MSG[5];
    e_x = expect_next(SEL[5], MSG[5]);
    #1;
    check(in_ready0 == 1'b0, "R7 not ready while stalled", SW'(in_ready0), SW'(0));
    @(negedge clk);
    check(out_state0 == e_last && out_valid0, "R6 held under stall", out_state0, e_last);
    @(negedge clk);
    check(out_state0 == e_last && out_valid0, "R6 held second cycle", out_state0, e_last);
    rdy0 = 1'b1;
    #1;
    check(in_ready0 == 1'b1, "R7 ready when drained", SW'(in_ready0), SW'(1));
    @(negedge clk);
    check(out_state0 == e_x, "R5 load after stall", out_state0, e_x);

    // R10: idle cycles, input changes are ignored
    in_valid = 1'b0;
    in_state = build(SEL[2]);
    @(negedge clk);
    check(out_valid0 == 1'b0, "R10 valid drops when idle", SW'(out_valid0), SW'(0));
    check(out_state0 == e_x, "R10 state kept when idle", out_state0, e_x);
    in_state = build(SEL[6]);
    in_msg   = MSG[6];
    @(negedge clk);
    check(out_state0 == e_x, "R10 idle input ignored", out_state0, e_x);

    // R9: pass-through handshake of the combinational build
    rdy1 = 1'b0;
    #1;
    check(in_ready1 == 1'b0 && out_valid1 == 1'b0, "R9 handshake pass-through",
          SW'({in_ready1, out_valid1}), SW'(0));
    rdy1 = 1'b1;
    #1;
    check(in_ready1 == 1'b1, "R9 ready follows", SW'(in_ready1), SW'(1));

    // R8: reset during traffic
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check(out_valid0 == 1'b0 && out_state0 == '0, "R8 reset clears",
          out_state0, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule